// File: doc/BRIEF.md
# HDLC Receive-Line Event Register

This block keeps a sticky record of status events for one HDLC serial channel and raises a single interrupt request from them. It watches the serial receive line, sampled on a bit enable, to find flag octets (`01111110`) and long runs of ones. It also takes single-cycle strobes from the neighbouring receive and transmit engines: buffer completion, frame completion, transmit error, busy, graceful-stop completion, clock glitches and carrier-detect change.

Every event sets one bit of a 16-bit event vector. The bit stays set until software writes a one to that position. A mask vector with the same layout selects which set bits drive `irq_o`. The request stays high until every set and unmasked bit has been cleared. Software can read both vectors at any time.

Top module: `hdlc_evt_unit`

## Requirements
- R1: A clear write (`evt_clr_we_i` high) clears every event bit whose `evt_clr_data_i` bit is 1. Several bits can be cleared in one write. Bits written with 0 keep their value, and no event bit falls without a clear write.
- R2: `irq_o` stays high while any event bit is set and masked in. It falls only after the last such bit has been cleared.
- R3: After reset, `event_o`, `mask_o` and `irq_o` are all zero.
- R4: Bits 15, 14, 13, 6 and 5 of `event_o` and `mask_o` always read zero, and writes to them have no effect. The implemented positions form 16'h1F9F.
- R5: A one-cycle strobe sets its event bit in the next cycle, and the bit stays set. The mapping is: bit 0 receive buffer done, bit 1 transmit buffer done, bit 2 busy, bit 3 frame received, bit 4 transmit error, bit 7 graceful stop done, bit 10 carrier-detect change, bit 11 transmit clock glitch, bit 12 receive clock glitch.
- R6: A flag is the last eight enabled line bits equal to `01111110`, with the first bit received first. The first flag after a period with no flags sets bit 9.
- R7: When eight enabled bits pass after the last flag with no new flag, bit 9 is set again to mark the end of flag reception. Flags that follow back to back do not set it.
- R8: Fifteen enabled ones in a row set bit 8. The run count then restarts, so each further 15 ones set bit 8 again. An enabled zero restarts the count.
- R9: `rx_bit_i` is ignored in any cycle where `rx_bit_en_i` is low.
- R10: If an event and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R11: `irq_o` is the OR over all positions of event bit AND mask bit. A masked-out event is still recorded but does not raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Serial receive line value |
| rx_bit_en_i | input | 1 | Receive bit enable, one cycle per line bit |
| rx_buf_done_i | input | 1 | Strobe: receive buffer closed |
| tx_buf_done_i | input | 1 | Strobe: transmit buffer sent |
| busy_i | input | 1 | Strobe: frame lost, no free buffer |
| frame_rx_i | input | 1 | Strobe: complete frame received |
| tx_err_i | input | 1 | Strobe: transmit error |
| gstop_done_i | input | 1 | Strobe: graceful stop done |
| cd_change_i | input | 1 | Strobe: carrier-detect changed |
| tx_glitch_i | input | 1 | Strobe: glitch on transmit clock |
| rx_glitch_i | input | 1 | Strobe: glitch on receive clock |
| evt_clr_we_i | input | 1 | Clear-write strobe for the event vector |
| evt_clr_data_i | input | 16 | Ones select the event bits to clear |
| mask_we_i | input | 1 | Mask write strobe |
| mask_data_i | input | 16 | New mask value |
| event_o | output | 16 | Event vector |
| mask_o | output | 16 | Mask vector |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the end-of-flag event. The line must first carry a full flag, then a second flag back to back that must not produce an event, and then exactly eight non-flag bits chosen so that no window among them forms the pattern. The bench shifts these bits in one enable pulse at a time and clears bit 9 between the phases, so each setting of bit 9 can be checked on its own. The idle run restart is reached the same way: exact counts of 14 and 15 ones, with a zero or disabled cycles placed inside the run.

// File: rtl/hdlc_evt_pkg.sv
package hdlc_evt_pkg;
  localparam int EVT_W = 16;

  localparam int B_RX_BUF  = 0;
  localparam int B_TX_BUF  = 1;
  localparam int B_BUSY    = 2;
  localparam int B_RX_FRM  = 3;
  localparam int B_TX_ERR  = 4;
  localparam int B_GSTOP   = 7;
  localparam int B_IDLE    = 8;
  localparam int B_FLAG    = 9;
  localparam int B_CD_CHG  = 10;
  localparam int B_TX_GLT  = 11;
  localparam int B_RX_GLT  = 12;

  // positions backed by storage; the rest read zero
  localparam logic [EVT_W-1:0] IMPL_MASK = 16'h1F9F;

  typedef logic [EVT_W-1:0] evt_vec_t;
endpackage

// File: rtl/hdlc_line_watch.sv
module hdlc_line_watch #(
  parameter int          FLAG_W   = 8,
  parameter logic [7:0]  FLAG_PAT = 8'h7E,
  parameter int          IDLE_RUN = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_bit_i,
  input  logic rx_bit_en_i,
  output logic flag_evt_o,
  output logic idle_evt_o
);
  localparam int GAP_CW  = $clog2(FLAG_W + 1);
  localparam int IDLE_CW = $clog2(IDLE_RUN + 1);
  localparam logic [GAP_CW-1:0]  GAP_LAST  = GAP_CW'(FLAG_W - 1);
  localparam logic [IDLE_CW-1:0] IDLE_LAST = IDLE_CW'(IDLE_RUN - 1);

  logic [FLAG_W-1:0]  sr_q, sr_nxt;
  logic               flag_act_q;
  logic [GAP_CW-1:0]  gap_q;
  logic [IDLE_CW-1:0] ones_q;
  logic               hit, gap_end, run_end;

  always_comb begin
    sr_nxt  = {sr_q[FLAG_W-2:0], rx_bit_i};
    hit     = rx_bit_en_i && (sr_nxt == FLAG_PAT[FLAG_W-1:0]);
    gap_end = rx_bit_en_i && !hit && flag_act_q && (gap_q == GAP_LAST);
    run_end = rx_bit_en_i && rx_bit_i && (ones_q == IDLE_LAST);
  end

  // flag window: active from first flag until a full octet without one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q       <= '0;
      flag_act_q <= 1'b0;
      gap_q      <= '0;
    end else if (rx_bit_en_i) begin
      sr_q <= sr_nxt;
      if (hit) begin
        flag_act_q <= 1'b1;
        gap_q      <= '0;
      end else if (gap_end) begin
        flag_act_q <= 1'b0;
        gap_q      <= '0;
      end else if (flag_act_q) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   ones_q <= '0;
    else if (rx_bit_en_i) begin
      if (!rx_bit_i || run_end)    ones_q <= '0;
      else                         ones_q <= ones_q + 1'b1;
    end
  end

  assign flag_evt_o = (hit && !flag_act_q) || gap_end;
  assign idle_evt_o = run_end;
endmodule

// File: rtl/hdlc_evt_store.sv
module hdlc_evt_store
  import hdlc_evt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  evt_vec_t set_i,
  input  logic     clr_we_i,
  input  evt_vec_t clr_data_i,
  output evt_vec_t evt_o
);
  evt_vec_t evt_q, clr_sel;

  assign clr_sel = clr_we_i ? clr_data_i : '0;

  // new event overrides a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= ((evt_q & ~clr_sel) | set_i) & IMPL_MASK;
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/hdlc_irq_mask.sv
module hdlc_irq_mask
  import hdlc_evt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     mask_we_i,
  input  evt_vec_t mask_data_i,
  input  evt_vec_t evt_i,
  output evt_vec_t mask_o,
  output logic     irq_o
);
  evt_vec_t mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_data_i & IMPL_MASK;
  end

  assign mask_o = mask_q;
  assign irq_o  = |(evt_i & mask_q);
endmodule

// File: rtl/hdlc_evt_unit.sv
module hdlc_evt_unit
  import hdlc_evt_pkg::*;
#(
  parameter int IDLE_RUN = 15
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_bit_i,
  input  logic        rx_bit_en_i,
  input  logic        rx_buf_done_i,
  input  logic        tx_buf_done_i,
  input  logic        busy_i,
  input  logic        frame_rx_i,
  input  logic        tx_err_i,
  input  logic        gstop_done_i,
  input  logic        cd_change_i,
  input  logic        tx_glitch_i,
  input  logic        rx_glitch_i,
  input  logic        evt_clr_we_i,
  input  logic [15:0] evt_clr_data_i,
  input  logic        mask_we_i,
  input  logic [15:0] mask_data_i,
  output logic [15:0] event_o,
  output logic [15:0] mask_o,
  output logic        irq_o
);
  logic     flag_evt, idle_evt;
  evt_vec_t set_vec, evt_q;

  hdlc_line_watch #(
    .FLAG_W   (8),
    .FLAG_PAT (8'h7E),
    .IDLE_RUN (IDLE_RUN)
  ) u_watch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_bit_i    (rx_bit_i),
    .rx_bit_en_i (rx_bit_en_i),
    .flag_evt_o  (flag_evt),
    .idle_evt_o  (idle_evt)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[B_RX_BUF]  = rx_buf_done_i;
    set_vec[B_TX_BUF]  = tx_buf_done_i;
    set_vec[B_BUSY]    = busy_i;
    set_vec[B_RX_FRM]  = frame_rx_i;
    set_vec[B_TX_ERR]  = tx_err_i;
    set_vec[B_GSTOP]   = gstop_done_i;
    set_vec[B_IDLE]    = idle_evt;
    set_vec[B_FLAG]    = flag_evt;
    set_vec[B_CD_CHG]  = cd_change_i;
    set_vec[B_TX_GLT]  = tx_glitch_i;
    set_vec[B_RX_GLT]  = rx_glitch_i;
  end

  hdlc_evt_store u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_vec),
    .clr_we_i   (evt_clr_we_i),
    .clr_data_i (evt_clr_data_i),
    .evt_o      (evt_q)
  );

  hdlc_irq_mask u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mask_we_i   (mask_we_i),
    .mask_data_i (mask_data_i),
    .evt_i       (evt_q),
    .mask_o      (mask_o),
    .irq_o       (irq_o)
  );

  assign event_o = evt_q;
endmodule

// File: rtl/hdlc_evt_unit_chk.sv
module hdlc_evt_unit_chk
  import hdlc_evt_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rx_buf_done_i,
  input logic        evt_clr_we_i,
  input logic [15:0] evt_clr_data_i,
  input logic        mask_we_i,
  input logic [15:0] event_o,
  input logic [15:0] mask_o,
  input logic        irq_o
);
  AST_RSVD_EVT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o & ~IMPL_MASK) == '0); // R4
  AST_RSVD_MASK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o & ~IMPL_MASK) == '0); // R4
  AST_NO_SPONT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_clr_we_i |=> (($past(event_o) & ~event_o) == '0)); // R1
  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_clr_we_i |=> (($past(event_o) & ~$past(evt_clr_data_i) & ~event_o) == '0)); // R1
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_buf_done_i |=> event_o[B_RX_BUF]); // R10
  AST_IRQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !evt_clr_we_i && !mask_we_i) |=> irq_o); // R2
endmodule

bind hdlc_evt_unit hdlc_evt_unit_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .rx_buf_done_i  (rx_buf_done_i),
  .evt_clr_we_i   (evt_clr_we_i),
  .evt_clr_data_i (evt_clr_data_i),
  .mask_we_i      (mask_we_i),
  .event_o        (event_o),
  .mask_o         (mask_o),
  .irq_o          (irq_o)
);

// File: tb/sim_hdlc_evt_unit.sv
`timescale 1ns/1ps
module sim_hdlc_evt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_bit = 1'b1, rx_en = 1'b0;
  logic [15:0] stb = '0;
  logic        clr_we = 1'b0, mask_we = 1'b0;
  logic [15:0] clr_data = '0, mask_data = '0;
  logic [15:0] event_o, mask_o;
  logic        irq_o;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  hdlc_evt_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_bit_i(rx_bit), .rx_bit_en_i(rx_en),
    .rx_buf_done_i(stb[0]), .tx_buf_done_i(stb[1]), .busy_i(stb[2]),
    .frame_rx_i(stb[3]), .tx_err_i(stb[4]), .gstop_done_i(stb[7]),
    .cd_change_i(stb[10]), .tx_glitch_i(stb[11]), .rx_glitch_i(stb[12]),
    .evt_clr_we_i(clr_we), .evt_clr_data_i(clr_data),
    .mask_we_i(mask_we), .mask_data_i(mask_data),
    .event_o(event_o), .mask_o(mask_o), .irq_o(irq_o)
  );

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pulse(int idx);
    stb[idx] = 1'b1;
    @(negedge clk);
    stb = '0;
  endtask

  task automatic clear(logic [15:0] d);
    clr_we = 1'b1; clr_data = d;
    @(negedge clk);
    clr_we = 1'b0; clr_data = '0;
  endtask

  task automatic set_mask(logic [15:0] d);
    mask_we = 1'b1; mask_data = d;
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  task automatic send_bit(logic b);
    rx_bit = b; rx_en = 1'b1;
    @(negedge clk);
    rx_en = 1'b0;
  endtask

  task automatic send_ones(int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic t_reset;
    check("R3 event", event_o, 16'h0);
    check("R3 mask", mask_o, 16'h0);
    check("R3 irq", {15'h0, irq_o}, 16'h0);
  endtask

  task automatic t_strobes;
    logic [15:0] exp = '0;
    int idx[9] = '{0, 1, 2, 3, 4, 7, 10, 11, 12};
    foreach (idx[k]) begin
      pulse(idx[k]);
      exp[idx[k]] = 1'b1;
      check("R5 strobe map", event_o, exp);
    end
    @(negedge clk);
    check("R5 sticky", event_o, 16'h1C9F);
    clear(16'hFFFF);
    check("R1 clear all", event_o, 16'h0);
  endtask

  task automatic t_w1c;
    pulse(0); pulse(1); pulse(2);
    clear(16'h0002);
    check("R1 single clear", event_o, 16'h0005);
    clear(16'h0000);
    check("R1 zero write", event_o, 16'h0005);
    clear(16'h0005);
    check("R1 multi clear", event_o, 16'h0000);
  endtask

  task automatic t_reserved;
    set_mask(16'hFFFF);
    check("R4 mask reserved", mask_o, 16'h1F9F);
    set_mask(16'h0000);
  endtask

  task automatic t_irq;
    set_mask(16'h0009);
    pulse(2);
    check("R11 masked event kept", event_o, 16'h0004);
    check("R11 masked no irq", {15'h0, irq_o}, 16'h0);
    pulse(0); pulse(3);
    check("R11 irq raised", {15'h0, irq_o}, 16'h1);
    clear(16'h0001);
    check("R2 irq held", {15'h0, irq_o}, 16'h1);
    clear(16'h0008);
    check("R2 irq dropped", {15'h0, irq_o}, 16'h0);
    check("R2 masked bit left", event_o, 16'h0004);
    clear(16'hFFFF);
    set_mask(16'h0000);
  endtask

  task automatic t_set_wins;
    stb[4] = 1'b1; clr_we = 1'b1; clr_data = 16'h0010;
    @(negedge clk);
    stb = '0; clr_we = 1'b0; clr_data = '0;
    check("R10 set over clear", event_o, 16'h0010);
    clear(16'h0010);
    check("R10 later clear", event_o, 16'h0);
  endtask

  task automatic t_flag;
    logic [7:0] flag = 8'h7E;
    logic [7:0] data = 8'hA4;
    for (int i = 7; i > 0; i--) send_bit(flag[i]);
    check("R6 partial flag", event_o, 16'h0);
    send_bit(flag[0]);
    check("R6 flag start", event_o, 16'h0200);
    clear(16'h0200);
    for (int i = 7; i >= 0; i--) send_bit(flag[i]);
    check("R7 back to back flag", event_o, 16'h0);
    for (int i = 7; i > 0; i--) send_bit(data[i]);
    check("R7 gap not yet", event_o, 16'h0);
    send_bit(data[0]);
    check("R7 flag end", event_o, 16'h0200);
    clear(16'hFFFF);
  endtask

  task automatic t_idle;
    send_bit(1'b0);
    send_ones(14);
    check("R8 14 ones", event_o, 16'h0);
    send_bit(1'b1);
    check("R8 15 ones", event_o, 16'h0100);
    clear(16'h0100);
    send_ones(14);
    check("R8 rearm partial", event_o, 16'h0);
    send_bit(1'b1);
    check("R8 rearm", event_o, 16'h0100);
    clear(16'h0100);
    send_ones(10); send_bit(1'b0); send_ones(14);
    check("R8 zero restarts", event_o, 16'h0);
    send_bit(1'b1);
    check("R8 after restart", event_o, 16'h0100);
    clear(16'hFFFF);
  endtask

  task automatic t_enable;
    send_bit(1'b0);
    send_ones(14);
    rx_bit = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 disabled zeros", event_o, 16'h0);
    send_bit(1'b1);
    check("R9 run unbroken", event_o, 16'h0100);
    clear(16'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_strobes;
    t_w1c;
    t_reserved;
    t_irq;
    t_set_wins;
    t_flag;
    t_idle;
    t_enable;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule